// File: doc/BRIEF.md
# Nested interrupt priority controller

This block decides which interrupt a small processor core takes next and keeps track of the priority level the core is running at. Each of the fourteen vector slots has a 2-bit priority field. These fields are packed four to a byte in a set of byte-wide priority registers, which software reads and writes through a simple register port. The core's current level is a separate 2-bit value. It is loaded on every interrupt entry, restored on every return, and can also be written directly.

Maskable requests arrive on vectors 1 to 13 as level-sensitive pending lines. The top-level interrupt and the trap arrive as single-cycle event pulses and are taken whatever the current level is. Vector 0 is the slot of the top-level interrupt. When a request is accepted, the block raises a one-cycle take strobe, presents the vector index, and loads the new current level, all on the same clock edge. Before that it saves the interrupted level on a small internal stack. A return pops that stack. The stack holds four entries by default.

Top module: `nipc_ctrl`

## Requirements
- R1: A level is a 2-bit code with ranks 10 = 0, 01 = 1, 00 = 2 and 11 = 3 (3 is highest). A pending maskable vector is accepted only when its rank is strictly greater than the rank of the current level.
- R2: Priority register n (address n, 0..3) holds vectors 4n..4n+3. Vector k occupies bits [2(k mod 4)+1 : 2(k mod 4)]. Read data is combinational on the address. Bit positions with no vector (bits 7:4 of register 3) are read-only and read as 1.
- R3: Writing the code 10 into any field leaves that field unchanged, while the other fields of the same byte update. For example, CFh written with 64h gives 44h.
- R4: Among eligible maskable vectors, the one with the highest rank wins and a tie goes to the lower index. The field of vector 0 can be read and written but never takes part in maskable arbitration.
- R5: When a maskable vector is taken, take_o is high for one cycle after the clock edge that follows the request. On that same edge vec_o becomes the vector index and cur_lvl_o becomes that vector's field.
- R6: A trap pulse or a top-level pulse is taken even at level 3. It gives vec_o = 14 for the trap and 0 for the top-level interrupt, and cur_lvl_o = 11. The trap wins when both arrive together.
- R7: Every take pushes the previous level onto the stack and every return pops it into cur_lvl_o. A push onto a full stack drops the oldest entry. A pop of an empty stack yields 11.
- R8: A direct level write loads any code, 10 included. Precedence in a cycle is: event pulse, then return, then level write, then maskable take. No maskable take happens in a cycle that has a return or a level write.
- R9: After reset, cur_lvl_o is 11, take_o is 0 and every priority register reads FFh.
- R10: Raising the field of the vector being serviced re-takes it, one cycle after the write, if it is still pending. A field that is equal or lower takes effect only after the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Priority register write strobe |
| reg_addr_i | input | 2 | Priority register address (read and write) |
| reg_wdata_i | input | 8 | Priority register write data |
| reg_rdata_o | output | 8 | Priority register read data |
| lvl_wr_i | input | 1 | Direct write of the current level |
| lvl_wdata_i | input | 2 | Value for the direct level write |
| irq_req_i | input | 13 | Pending lines of vectors 13..1 (bit k = vector k) |
| tli_i | input | 1 | Top-level interrupt event pulse |
| trap_i | input | 1 | Trap event pulse |
| ret_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | 4 | Index of the vector taken (14 = trap) |
| cur_lvl_o | output | 2 | Current level code |

## Verification
A corrupted priority field shows up on reg_rdata_o as soon as its register is read. It also shows up at the next arbitration that involves that vector, where the wrong vector or the wrong level appears one edge after the request. A bad stack entry stays hidden until the matching return, and then it appears on cur_lvl_o on the very next edge. Mixing long chains of nested takes and returns with level writes and random field rewrites therefore brings stale or shifted stack entries out at the ports within a handful of cycles.

// File: rtl/nipc_pkg.sv
package nipc_pkg;
   typedef logic [1:0] lvl_code_t;

   // code that is refused in priority fields (lowest rank)
   localparam lvl_code_t LVL_MAIN = 2'b10;
   // highest rank, maskable interrupts disabled
   localparam lvl_code_t LVL_TOP  = 2'b11;

   // rank of a level code: 10->0, 01->1, 00->2, 11->3
   function automatic logic [1:0] code_rank(lvl_code_t c);
      return {~(c[1] ^ c[0]), c[0]};
   endfunction
endpackage

// File: rtl/nipc_prio_regs.sv
module nipc_prio_regs
   import nipc_pkg::*;
#(
   parameter int N_VEC = 14,
   parameter int DW    = 8,
   localparam int PPR  = DW / 2,
   localparam int NREG = (N_VEC + PPR - 1) / PPR,
   localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_i,
   input  logic [AW-1:0]           addr_i,
   input  logic [DW-1:0]           wdata_i,
   output logic [DW-1:0]           rdata_o,
   output logic [N_VEC-1:0][1:0]   pair_o
);
   generate
      if (DW % 2 != 0 || DW < 2) begin : g_bad_dw
         $error("nipc_prio_regs: DW must be even");
      end
      if (N_VEC < 2) begin : g_bad_nvec
         $error("nipc_prio_regs: N_VEC must be at least 2");
      end
   endgenerate

   logic [N_VEC-1:0][1:0] pair_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_VEC; k++) pair_q[k] <= LVL_TOP;
      end else if (wr_i) begin
         for (int k = 0; k < N_VEC; k++) begin
            if ((k / PPR) == int'(addr_i) &&
                wdata_i[2*(k%PPR) +: 2] != LVL_MAIN)
               pair_q[k] <= wdata_i[2*(k%PPR) +: 2];
         end
      end
   end

   always_comb begin
      rdata_o = '1;
      for (int j = 0; j < PPR; j++) begin
         if (int'(addr_i) * PPR + j < N_VEC)
            rdata_o[2*j +: 2] = pair_q[int'(addr_i) * PPR + j];
      end
   end

   assign pair_o = pair_q;

   generate
      for (genvar k = 0; k < N_VEC; k++) begin : g_pair_chk
         localparam int RIDX = k / PPR;
         localparam int BITP = 2 * (k % PPR);
         // R3
         lvl0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && int'(addr_i) == RIDX && wdata_i[BITP +: 2] == LVL_MAIN)
            |=> $stable(pair_q[k]));
      end
      if (NREG * PPR > N_VEC) begin : g_pad_chk
         localparam int PADB = 2 * (N_VEC - (NREG - 1) * PPR);
         // R2
         pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(addr_i) == NREG - 1) |-> (&rdata_o[DW-1:PADB]));
      end
   endgenerate
endmodule

// File: rtl/nipc_arbiter.sv
module nipc_arbiter
   import nipc_pkg::*;
#(
   parameter int N_VEC = 14,
   parameter int VW    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_VEC-1:1]      req_i,
   input  logic [N_VEC-1:0][1:0] pair_i,
   input  lvl_code_t             cur_i,
   output logic                  win_o,
   output logic [VW-1:0]         idx_o,
   output lvl_code_t             code_o
);
   logic [1:0]       best_rank;
   logic [N_VEC-1:0] req_full;

   assign req_full = {req_i, 1'b0};

   // ascending scan with strict compare: ties stay with the lower index
   always_comb begin
      best_rank = code_rank(cur_i);
      win_o     = 1'b0;
      idx_o     = '0;
      code_o    = cur_i;
      for (int k = 1; k < N_VEC; k++) begin
         if (req_i[k] && code_rank(pair_i[k]) > best_rank) begin
            best_rank = code_rank(pair_i[k]);
            win_o     = 1'b1;
            idx_o     = VW'(k);
            code_o    = pair_i[k];
         end
      end
   end

   // R4
   win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_o |-> (req_full[idx_o] && idx_o != '0));
   // R1
   win_above_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_o |-> (code_rank(code_o) > code_rank(cur_i)));
endmodule

// File: rtl/nipc_lvl_stack.sv
module nipc_lvl_stack
   import nipc_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push_i,
   input  logic      pop_i,
   input  lvl_code_t din_i,
   output lvl_code_t top_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("nipc_lvl_stack: DEPTH must be at least 2");
      end
   endgenerate

   lvl_code_t stk_q [DEPTH];

   // shift-register stack: the oldest entry falls off, empty slots read 11
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) stk_q[d] <= LVL_TOP;
      end else if (push_i) begin
         stk_q[0] <= din_i;
         for (int d = 1; d < DEPTH; d++) stk_q[d] <= stk_q[d-1];
      end else if (pop_i) begin
         for (int d = 0; d < DEPTH - 1; d++) stk_q[d] <= stk_q[d+1];
         stk_q[DEPTH-1] <= LVL_TOP;
      end
   end

   assign top_o = stk_q[0];

   // R7
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> (top_o == $past(din_i)));
   // R8
   push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
endmodule

// File: rtl/nipc_ctrl.sv
module nipc_ctrl
   import nipc_pkg::*;
#(
   parameter int N_VEC     = 14,
   parameter int STK_DEPTH = 4,
   parameter int DW        = 8,
   localparam int VW       = $clog2(N_VEC + 1),
   localparam int PPR      = DW / 2,
   localparam int NREG     = (N_VEC + PPR - 1) / PPR,
   localparam int AW       = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [AW-1:0]     reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   input  logic              lvl_wr_i,
   input  logic [1:0]        lvl_wdata_i,
   input  logic [N_VEC-1:1]  irq_req_i,
   input  logic              tli_i,
   input  logic              trap_i,
   input  logic              ret_i,
   output logic              take_o,
   output logic [VW-1:0]     vec_o,
   output logic [1:0]        cur_lvl_o
);
   localparam logic [VW-1:0] TRAP_IDX = VW'(N_VEC);

   logic [N_VEC-1:0][1:0] pairs;
   logic                  win;
   logic [VW-1:0]         win_idx;
   lvl_code_t             win_code;
   lvl_code_t             stk_top;
   lvl_code_t             cur_q;
   logic                  take_q;
   logic [VW-1:0]         vec_q;
   logic                  evt, push, pop;

   nipc_prio_regs #(.N_VEC(N_VEC), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .pair_o(pairs)
   );

   nipc_arbiter #(.N_VEC(N_VEC), .VW(VW)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(irq_req_i), .pair_i(pairs),
      .cur_i(cur_q), .win_o(win), .idx_o(win_idx), .code_o(win_code)
   );

   assign evt  = tli_i | trap_i;
   assign push = evt | (win & ~ret_i & ~lvl_wr_i);
   assign pop  = ~evt & ret_i;

   nipc_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
      .din_i(cur_q), .top_o(stk_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= LVL_TOP;
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= push;
         if (evt) begin
            cur_q <= LVL_TOP;
            vec_q <= trap_i ? TRAP_IDX : '0;
         end else if (ret_i) begin
            cur_q <= stk_top;
         end else if (lvl_wr_i) begin
            cur_q <= lvl_wdata_i;
         end else if (win) begin
            cur_q <= win_code;
            vec_q <= win_idx;
         end
      end
   end

   assign take_o    = take_q;
   assign vec_o     = vec_q;
   assign cur_lvl_o = cur_q;

   // R6
   evt_top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (vec_o == '0 || vec_o == TRAP_IDX)) |-> (cur_lvl_o == LVL_TOP));
   // R5
   take_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && vec_o != '0 && vec_o != TRAP_IDX)
      |-> (code_rank(cur_lvl_o) > code_rank($past(cur_lvl_o))));
   // R8
   lvl_wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_wr_i && !evt && !ret_i) |=> (!take_o && cur_lvl_o == $past(lvl_wdata_i)));
   // R7
   ret_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !evt) |=> !take_o);
endmodule

// File: tb/test_nipc_ctrl.sv
`timescale 1ns/1ps
module test_nipc_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [1:0]  reg_addr_i = '0;
   logic [7:0]  reg_wdata_i = '0;
   logic [7:0]  reg_rdata_o;
   logic        lvl_wr_i = 1'b0;
   logic [1:0]  lvl_wdata_i = '0;
   logic [13:1] irq_req_i = '0;
   logic        tli_i = 1'b0;
   logic        trap_i = 1'b0;
   logic        ret_i = 1'b0;
   logic        take_o;
   logic [3:0]  vec_o;
   logic [1:0]  cur_lvl_o;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   logic [1:0] m_pair [14];
   logic [1:0] m_cur;
   logic [1:0] m_stk [4];
   logic [3:0] m_vec;

   always #2.5 clk = ~clk;

   nipc_ctrl i_nipc_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .lvl_wr_i(lvl_wr_i),
      .lvl_wdata_i(lvl_wdata_i), .irq_req_i(irq_req_i), .tli_i(tli_i),
      .trap_i(trap_i), .ret_i(ret_i), .take_o(take_o), .vec_o(vec_o),
      .cur_lvl_o(cur_lvl_o)
   );

   function automatic int rank_of(logic [1:0] c);
      case (c)
         2'b10:   return 0;
         2'b01:   return 1;
         2'b00:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(logic [1:0] a);
      logic [7:0] r = 8'hFF;
      for (int j = 0; j < 4; j++)
         if (int'(a) * 4 + j < 14) r[2*j +: 2] = m_pair[int'(a) * 4 + j];
      return r;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic m_push(logic [1:0] v);
      for (int d = 3; d > 0; d--) m_stk[d] = m_stk[d-1];
      m_stk[0] = v;
   endtask

   task automatic step(string tag, logic [13:1] req, logic wr, logic [1:0] a,
                       logic [7:0] d, logic lw, logic [1:0] ld,
                       logic tli, logic trap, logic ret);
      logic       e_take;
      int         best;
      @(negedge clk);
      irq_req_i = req; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
      lvl_wr_i = lw; lvl_wdata_i = ld; tli_i = tli; trap_i = trap; ret_i = ret;
      e_take = 1'b0;
      if (trap || tli) begin
         e_take = 1'b1;
         m_vec = trap ? 4'd14 : 4'd0;
         m_push(m_cur);
         m_cur = 2'b11;
      end else if (ret) begin
         m_cur = m_stk[0];
         for (int k = 0; k < 3; k++) m_stk[k] = m_stk[k+1];
         m_stk[3] = 2'b11;
      end else if (lw) begin
         m_cur = ld;
      end else begin
         best = rank_of(m_cur);
         for (int k = 1; k < 14; k++) begin
            if (req[k] && rank_of(m_pair[k]) > best) begin
               best = rank_of(m_pair[k]);
               m_vec = 4'(k);
               e_take = 1'b1;
            end
         end
         if (e_take) begin
            m_push(m_cur);
            m_cur = m_pair[m_vec];
         end
      end
      if (wr)
         for (int j = 0; j < 4; j++)
            if (int'(a) * 4 + j < 14 && d[2*j +: 2] != 2'b10)
               m_pair[int'(a) * 4 + j] = d[2*j +: 2];
      @(posedge clk);
      #1;
      chk(tag, "take", int'(take_o), int'(e_take));
      if (e_take) chk(tag, "vec", int'(vec_o), int'(m_vec));
      chk(tag, "cur_lvl", int'(cur_lvl_o), int'(m_cur));
      chk("R2", "rdata", int'(reg_rdata_o), int'(exp_rd(a)));
   endtask

   task automatic idle(string tag);
      step(tag, '0, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [13:1] rq;
      void'($urandom(32'd20240611));
      for (int k = 0; k < 14; k++) m_pair[k] = 2'b11;
      for (int d = 0; d < 4; d++) m_stk[d] = 2'b11;
      m_cur = 2'b11;
      m_vec = 4'd0;

      // R9: reset state
      repeat (3) @(posedge clk);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         reg_addr_i = 2'(a);
         #1;
         chk("R9", "rdata", int'(reg_rdata_o), 255);
      end
      chk("R9", "take", int'(take_o), 0);
      chk("R9", "cur_lvl", int'(cur_lvl_o), 3);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: level 3 out of reset blocks maskable requests
      step("R9", 13'h1FFF, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      // R8: level 0 code accepted by a direct write
      step("R8", '0, 1'b0, 2'd0, 8'h00, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
      chk("R8", "cur_lvl direct", int'(cur_lvl_o), 2);
      // R3: per-field refusal of code 10
      step("R3", '0, 1'b1, 2'd1, 8'hCF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      step("R3", '0, 1'b1, 2'd1, 8'h64, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      chk("R3", "rdata 44h", int'(reg_rdata_o), 8'h44);
      // R2: read-only padding of the last register
      step("R2", '0, 1'b1, 2'd3, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      chk("R2", "rdata F0h", int'(reg_rdata_o), 8'hF0);
      // R4: vectors 4 and 6 tie at level 2, lower index wins
      rq = '0; rq[4] = 1'b1; rq[6] = 1'b1;
      step("R4", rq, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      chk("R4", "vec tie", int'(vec_o), 4);
      // R1: equal or lower levels are not accepted
      rq[5] = 1'b1;
      step("R1", rq, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      // R10: raise vector 4 to level 3 while it is still pending
      rq = '0; rq[4] = 1'b1;
      step("R10", rq, 1'b1, 2'd1, 8'h47, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      step("R10", rq, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      chk("R10", "re-entry vec", int'(vec_o), 4);
      chk("R10", "re-entry lvl", int'(cur_lvl_o), 3);
      // R7: returns unwind the levels
      step("R7", '0, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      step("R7", '0, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      chk("R7", "unwound lvl", int'(cur_lvl_o), 2);
      // R10: lowering the field of a serviced vector does not re-enter it
      step("R10", rq, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      step("R10", rq, 1'b1, 2'd1, 8'h45, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      step("R10", rq, 1'b0, 2'd1, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      // R6: events at level 3, and the trap wins over the top-level event
      step("R6", '0, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
      step("R6", '0, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
      chk("R6", "trap vec", int'(vec_o), 14);
      // R8: a return blocks a maskable take in the same cycle
      step("R8", 13'h1FFF, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      // R7: overflow drops the oldest entry, underflow yields 11
      step("R7", '0, 1'b0, 2'd0, 8'h00, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++)
         step("R7", '0, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++)
         step("R7", '0, 1'b0, 2'd0, 8'h00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
      chk("R7", "underflow lvl", int'(cur_lvl_o), 3);
      idle("R5");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [13:1] r_req;
         logic        r_wr, r_lw, r_tli, r_trap, r_ret;
         r_req  = 13'($urandom) & 13'($urandom);
         r_wr   = ($urandom % 5) == 0;
         r_lw   = ($urandom % 12) == 0;
         r_tli  = ($urandom % 40) == 0;
         r_trap = ($urandom % 50) == 0;
         r_ret  = ($urandom % 6) == 0;
         step("R5", r_req, r_wr, 2'($urandom), 8'($urandom), r_lw,
              2'($urandom), r_tli, r_trap, r_ret);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule